// File: doc/BRIEF.md
# Host-Bus Control and Status Register Block

This block sits on a host processor's byte-wide bus. It decodes three byte addresses. Two of them load write-only 8-bit control registers. The third is a read-only status port.

The processor control register drives the bank-select page for a banked system ROM. It also drives the control lines of a second processor: reset, diagnostic kernel mode, bus request and bus take.

The miscellaneous register holds six general control outputs and two diagnostic bits. The status port lets the host sample three external inputs: probe presence, an interrupt from the second processor and an interrupt from the panel processor. The same port returns the three diagnostic bits, so that self-test can write known patterns and read them back.

A write is committed when the active-low write strobe returns high. The block samples the strobe on its clock. The register is loaded on the clock edge at which the strobe is first seen high after having been seen low, using the address and data present at that edge. Power-up reset clears both registers, so every controlled function starts inactive.

Top module: `hostCtlRegs`

## Requirements
- R1: While `rstN` is low, `romPage`, `slaveReset`, `slaveKernel`, `slaveBusReq`, `slaveBusTake` and `miscCtl` are all 0, and both registers read back as zero diagnostic bits.
- R2: A register is loaded only on a clock edge at which `busWrStrobeN` is sampled 1 after it was sampled 0 at the previous edge. The address and data sampled at that edge are used. Edges at which the strobe is held low load nothing.
- R3: A write to address 0x6014 loads the processor control register, and `romPage` equals its bits 2:0.
- R4: Bit 3 of the processor control register drives `slaveReset`, bit 4 drives `slaveKernel` and bit 5 drives `slaveBusReq`.
- R5: `slaveBusTake` equals bit 6 AND bit 5 of the processor control register. A take without a request is masked.
- R6: A write to address 0x6015 loads the miscellaneous register. `miscCtl` equals its bits 5:0. Its bit 7 is diagnostic bit 1 and its bit 6 is diagnostic bit 2.
- R7: When `busRdStrobe` is 1 and `busAddr` is 0x6011, `busRdData` is {2'b00, diag2, diag1, diag0, panelIrq, slaveIrq, probePresent}, where diag0 is bit 7 of the processor control register. This value appears combinationally in the same cycle. Otherwise `busRdData` is 0.
- R8: A write strobe at any address other than 0x6014 or 0x6015, including 0x6011, leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Power-up reset, active low, asynchronous |
| busAddr | input | 16 | Host byte address |
| busWrData | input | 8 | Host write data |
| busWrStrobeN | input | 1 | Write strobe, active low; commits on return high |
| busRdStrobe | input | 1 | Read strobe, active high |
| busRdData | output | 8 | Status byte or zero |
| probePresent | input | 1 | External probe detected |
| slaveIrq | input | 1 | Interrupt from the second processor |
| panelIrq | input | 1 | Interrupt from the panel processor |
| romPage | output | 3 | Bank-switched ROM page select |
| slaveReset | output | 1 | Reset to the second processor |
| slaveKernel | output | 1 | Diagnostic kernel mode for the second processor |
| slaveBusReq | output | 1 | Bus request to the second processor |
| slaveBusTake | output | 1 | Take over the second processor's buses (masked by request) |
| miscCtl | output | 6 | Miscellaneous control outputs |

## Verification
The bench holds the write strobe low across several edges while the data changes. This catches a design that loads on the falling edge or on every low cycle, because such a design would latch an early data value instead of the one present when the strobe rises.

The bench writes bit 6 without bit 5 to expose a design that passes bus take through unmasked. It strobes 0x6011 and nearby addresses to catch a decoder that compares too few address bits or lets a status write disturb a register.

Diagnostic loopback patterns with each diagnostic bit set alone would reveal swapped or misplaced status bits. A reset applied mid-run would reveal a register that is left out of the reset.

// File: rtl/hostRegsPkg.sv
package hostRegsPkg;
  typedef struct packed {
    logic loadPc;
    logic loadMisc;
    logic readStat;
  } regStrobeT;
endpackage

// File: rtl/hostRegsCtrl.sv
module hostRegsCtrl
  import hostRegsPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PC_ADDR = 16'h6014,
  parameter logic [ADDR_W-1:0] MISC_ADDR = 16'h6015,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h6011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrStrobeN,
  input  logic              rdStrobe,
  output regStrobeT         strb
);
  logic strobePrev;
  logic wrRise;

  // Remember the strobe level seen at the previous edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobePrev <= 1'b1;
    else       strobePrev <= wrStrobeN;
  end

  assign wrRise = !strobePrev && wrStrobeN;

  always_comb begin
    strb          = '0;
    strb.loadPc   = wrRise && (addr == PC_ADDR);
    strb.loadMisc = wrRise && (addr == MISC_ADDR);
    strb.readStat = rdStrobe && (addr == STAT_ADDR);
  end
endmodule

// File: rtl/hostRegsData.sv
module hostRegsData
  import hostRegsPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobeT         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              probePresent,
  input  logic              slaveIrq,
  input  logic              panelIrq,
  output logic [DATA_W-1:0] rdData,
  output logic [PAGE_W-1:0] romPage,
  output logic              slaveReset,
  output logic              slaveKernel,
  output logic              slaveBusReq,
  output logic              slaveBusTake,
  output logic [DATA_W-3:0] miscCtl
);
  localparam int RST_BIT  = PAGE_W;
  localparam int KERN_BIT = PAGE_W + 1;
  localparam int REQ_BIT  = PAGE_W + 2;
  localparam int TAKE_BIT = PAGE_W + 3;
  localparam int DIAG_HI  = DATA_W - 1;
  localparam int DIAG_LO  = DATA_W - 2;
  localparam int STAT_W   = 6;

  logic [DATA_W-1:0] pcReg;
  logic [DATA_W-1:0] miscReg;
  logic [STAT_W-1:0] statBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg   <= '0;
      miscReg <= '0;
    end else begin
      if (strb.loadPc)   pcReg   <= wrData;
      if (strb.loadMisc) miscReg <= wrData;
    end
  end

  assign romPage      = pcReg[PAGE_W-1:0];
  assign slaveReset   = pcReg[RST_BIT];
  assign slaveKernel  = pcReg[KERN_BIT];
  assign slaveBusReq  = pcReg[REQ_BIT];
  assign slaveBusTake = pcReg[TAKE_BIT] & pcReg[REQ_BIT];
  assign miscCtl      = miscReg[DATA_W-3:0];

  assign statBits = {miscReg[DIAG_LO], miscReg[DIAG_HI], pcReg[DIAG_HI],
                     panelIrq, slaveIrq, probePresent};

  always_comb begin
    rdData = '0;
    if (strb.readStat) rdData[STAT_W-1:0] = statBits;
  end
endmodule

// File: rtl/hostCtlRegs.sv
module hostCtlRegs
  import hostRegsPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 3,
  parameter logic [ADDR_W-1:0] PC_ADDR = 16'h6014,
  parameter logic [ADDR_W-1:0] MISC_ADDR = 16'h6015,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h6011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrStrobeN,
  input  logic              busRdStrobe,
  output logic [DATA_W-1:0] busRdData,
  input  logic              probePresent,
  input  logic              slaveIrq,
  input  logic              panelIrq,
  output logic [PAGE_W-1:0] romPage,
  output logic              slaveReset,
  output logic              slaveKernel,
  output logic              slaveBusReq,
  output logic              slaveBusTake,
  output logic [DATA_W-3:0] miscCtl
);
  regStrobeT strb;

  hostRegsCtrl #(
    .ADDR_W(ADDR_W), .PC_ADDR(PC_ADDR), .MISC_ADDR(MISC_ADDR), .STAT_ADDR(STAT_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .addr(busAddr), .wrStrobeN(busWrStrobeN),
    .rdStrobe(busRdStrobe), .strb(strb)
  );

  hostRegsData #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData),
    .probePresent(probePresent), .slaveIrq(slaveIrq), .panelIrq(panelIrq),
    .rdData(busRdData), .romPage(romPage), .slaveReset(slaveReset),
    .slaveKernel(slaveKernel), .slaveBusReq(slaveBusReq),
    .slaveBusTake(slaveBusTake), .miscCtl(miscCtl)
  );
endmodule

// File: rtl/hostCtlRegsChk.sv
module hostCtlRegsChk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] busAddr,
  input logic        busWrStrobeN,
  input logic        busRdStrobe,
  input logic [7:0]  busRdData,
  input logic        probePresent,
  input logic        slaveIrq,
  input logic        panelIrq,
  input logic [2:0]  romPage,
  input logic        slaveReset,
  input logic        slaveKernel,
  input logic        slaveBusReq,
  input logic        slaveBusTake,
  input logic [5:0]  miscCtl
);
  logic [11:0] ctlOuts;
  assign ctlOuts = {romPage, slaveReset, slaveKernel, slaveBusReq, slaveBusTake, miscCtl};

  // R1
  p_reset_clear_r1: assert property (@(posedge clk) !rstN |=> (ctlOuts == '0));
  // R2
  p_low_strobe_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busWrStrobeN |=> $stable(ctlOuts));
  // R5
  p_take_needs_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    slaveBusTake |-> slaveBusReq);
  // R7
  p_idle_read_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busRdStrobe |-> (busRdData == 8'h00));
  // R7
  p_status_inputs_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busRdStrobe && busAddr == 16'h6011) |->
      (busRdData[2:0] == {panelIrq, slaveIrq, probePresent} && busRdData[7:6] == 2'b00));
  // R8
  p_other_addr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != 16'h6014 && busAddr != 16'h6015) |=> $stable(ctlOuts));
endmodule

bind hostCtlRegs hostCtlRegsChk chk (.*);

// File: tb/tb_hostCtlRegs.sv
module tb_hostCtlRegs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = 16'h0000;
  logic [7:0]  busWrData = 8'h00;
  logic        busWrStrobeN = 1'b1;
  logic        busRdStrobe = 1'b0;
  logic [7:0]  busRdData;
  logic        probePresent = 1'b0;
  logic        slaveIrq = 1'b0;
  logic        panelIrq = 1'b0;
  logic [2:0]  romPage;
  logic        slaveReset, slaveKernel, slaveBusReq, slaveBusTake;
  logic [5:0]  miscCtl;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  hostCtlRegs dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrStrobeN(busWrStrobeN), .busRdStrobe(busRdStrobe), .busRdData(busRdData),
    .probePresent(probePresent), .slaveIrq(slaveIrq), .panelIrq(panelIrq),
    .romPage(romPage), .slaveReset(slaveReset), .slaveKernel(slaveKernel),
    .slaveBusReq(slaveBusReq), .slaveBusTake(slaveBusTake), .miscCtl(miscCtl)
  );

  // Behavioural reference state
  logic [7:0] mPc = 8'h00;
  logic [7:0] mMisc = 8'h00;
  logic       mPrevN = 1'b1;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPc = 8'h00; mMisc = 8'h00; mPrevN = 1'b1;
    end else begin
      if (mPrevN == 1'b0 && busWrStrobeN == 1'b1) begin
        if (busAddr == 16'h6014)      mPc = busWrData;
        else if (busAddr == 16'h6015) mMisc = busWrData;
      end
      mPrevN = busWrStrobeN;
    end
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // Compare every clock at the falling edge, before inputs move.
  always @(negedge clk) begin
    logic [7:0] rdExp;
    if (!finished) begin
      rdExp = (busRdStrobe && busAddr == 16'h6011) ?
              {2'b00, mMisc[6], mMisc[7], mPc[7], panelIrq, slaveIrq, probePresent} : 8'h00;
      if (!rstN) check("R1 reset outputs", {romPage, slaveReset, slaveKernel, slaveBusReq, slaveBusTake},
                       8'h00);
      check("R3 romPage", {5'b0, romPage}, {5'b0, mPc[2:0]});
      check("R4 reset/kernel/req", {5'b0, slaveReset, slaveKernel, slaveBusReq},
            {5'b0, mPc[3], mPc[4], mPc[5]});
      check("R5 busTake", {7'b0, slaveBusTake}, {7'b0, mPc[6] & mPc[5]});
      check("R6 miscCtl", {2'b0, miscCtl}, {2'b0, mMisc[5:0]});
      check("R7 rdData", busRdData, rdExp);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    step(); busAddr = a; busWrData = d; busWrStrobeN = 1'b0;
    step(); busWrStrobeN = 1'b1;
    step(); busAddr = 16'h0000; busWrData = 8'h00;
  endtask

  task automatic busRead(input logic [15:0] a);
    step(); busAddr = a; busRdStrobe = 1'b1;
    step(); busRdStrobe = 1'b0; busAddr = 16'h0000;
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #100000;
    compared++; mismatched++;
    $display("FAIL watchdog (all requirements): actual hung, expected finished");
    summary();
  end

  initial begin
    // R1: reset state observed over several clocks
    repeat (3) step();
    busRead(16'h6011);
    step(); rstN = 1'b1;
    busRead(16'h6011);
    // R3, R4: page select and control lines
    busWrite(16'h6014, 8'h05);
    busWrite(16'h6014, 8'h1A);
    busWrite(16'h6014, 8'h2F);
    // R5: take without request is masked, then with request
    busWrite(16'h6014, 8'h40);
    busWrite(16'h6014, 8'h60);
    busWrite(16'h6014, 8'hFF);
    // R6: misc register
    busWrite(16'h6015, 8'h2A);
    busWrite(16'h6015, 8'hD5);
    // R7: loopback of each diagnostic bit alone, with status inputs
    busWrite(16'h6014, 8'h80); busWrite(16'h6015, 8'h00);
    probePresent = 1'b1; busRead(16'h6011);
    busWrite(16'h6014, 8'h00); busWrite(16'h6015, 8'h80);
    probePresent = 1'b0; slaveIrq = 1'b1; busRead(16'h6011);
    busWrite(16'h6015, 8'h40);
    slaveIrq = 1'b0; panelIrq = 1'b1; busRead(16'h6011);
    busRead(16'h6010);
    busRead(16'h7011);
    panelIrq = 1'b0;
    // R8: strobes at other addresses change nothing
    busWrite(16'h6014, 8'h9B); busWrite(16'h6015, 8'h3C);
    busWrite(16'h6011, 8'h00);
    busWrite(16'h6016, 8'hFF);
    busWrite(16'h4014, 8'h00);
    busWrite(16'h6034, 8'h00);
    busRead(16'h6011);
    // R2: strobe held low over changing data; only the value at the rise counts
    step(); busAddr = 16'h6014; busWrData = 8'h11; busWrStrobeN = 1'b0;
    step(); busWrData = 8'h22;
    step(); busWrData = 8'h33;
    step(); busWrData = 8'h2C; busWrStrobeN = 1'b1;
    step(); busWrData = 8'h77;
    step(); busAddr = 16'h0000;
    // R2: address switched at the rise decides the target
    step(); busAddr = 16'h6014; busWrData = 8'h0E; busWrStrobeN = 1'b0;
    step(); busAddr = 16'h6015; busWrStrobeN = 1'b1;
    step(); busAddr = 16'h0000;
    // R2: strobe released during reset does not load afterwards
    step(); busAddr = 16'h6014; busWrData = 8'hFF; busWrStrobeN = 1'b0;
    step(); rstN = 1'b0;
    step(); step(); rstN = 1'b1; busWrStrobeN = 1'b1;
    step(); step(); busAddr = 16'h0000;
    busRead(16'h6011);
    busWrite(16'h6015, 8'h3F);
    repeat (4) step();
    summary();
  end
endmodule